// File: doc/BRIEF.md
# Memory Load CRC Checksum

This block keeps a running CRC-32 over the host's word writes into an instruction memory and a data memory. The host can then confirm that a program image arrived intact without reading it back. Each write that qualifies is turned into a 48-bit record made of a memory-select flag, the word index and the data word. The record is folded into the CRC state in the same cycle as the write strobe.

The host sees one 32-bit checksum value and can overwrite it. Before a load it normally writes zero. After the load it reads the value and compares it with a result from an ordinary software crc32 over the same records. Inside the block the state is kept as the bitwise complement of the visible value, so the visible numbers match the usual software conventions.

Top module: `memload_crc`

## Requirements
- R1: After reset the visible checksum reads 0x00000000, which means the internal state is all ones.
- R2: The update uses the reflected CRC-32 polynomial 0xEDB88320. The record is fed as six bytes, least significant byte first, so the visible result equals a standard software crc32 over the little-endian record, chained from the previous visible value.
- R3: The record is 48 bits. Bit 47 is the memory flag, bits 46:32 are the word index and bits 31:0 are the written data.
- R4: The memory flag is 1 when `wr_imem_i` is high (instruction memory) and 0 for data-memory writes.
- R5: The word index is the byte address shifted right by two, zero-extended to 15 bits.
- R6: A write that has any byte-enable bit low leaves the checksum unchanged.
- R7: A write whose byte address has bits 1:0 not equal to 00 leaves the checksum unchanged.
- R8: A host write to the checksum loads that value, and the next read returns it. Later records chain from the loaded value.
- R9: If a host checksum write and a memory write occur in the same cycle, the host value is loaded and the memory write is not counted.
- R10: A qualifying write shows in the checksum one clock edge after its strobe. Writes on back-to-back cycles are each counted.
- R11: In a cycle with no strobe the checksum holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Memory write strobe |
| wr_imem_i | input | 1 | 1 = instruction memory, 0 = data memory |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_be_i | input | 4 | Byte enables of the write |
| wr_data_i | input | 32 | Written data word |
| csum_we_i | input | 1 | Host write to the checksum register |
| csum_wdata_i | input | 32 | Value written to the checksum register |
| csum_o | output | 32 | Visible checksum |

## Verification
Two functions can fall in the same cycle: a memory write strobe and a host overwrite of the checksum. The bench provokes this by raising both strobes in the same cycle, once with a qualifying memory write. It judges the result by the visible checksum, which must equal the host value exactly. It then sends one more record and checks that the result chains from the host value, with no trace of the dropped memory write.

// File: rtl/memload_crc.sv
module memload_crc #(
  parameter int          ADDR_W = 14,
  parameter logic [31:0] POLY   = 32'hEDB88320
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              wr_imem_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [3:0]        wr_be_i,
  input  logic [31:0]       wr_data_i,
  input  logic              csum_we_i,
  input  logic [31:0]       csum_wdata_i,
  output logic [31:0]       csum_o
);
  localparam int IDX_W = 15;
  localparam int REC_W = 1 + IDX_W + 32;

  logic [31:0]      crc_q, crc_next;
  logic [IDX_W-1:0] word_idx;
  logic [REC_W-1:0] record;
  logic             counts;

  function automatic logic [31:0] fold(input logic [31:0] c, input logic [REC_W-1:0] r);
    logic [31:0] s;
    s = c;
    for (int i = 0; i < REC_W; i++)
      s = (s[0] ^ r[i]) ? ((s >> 1) ^ POLY) : (s >> 1);
    return s;
  endfunction

  assign word_idx = IDX_W'(wr_addr_i[ADDR_W-1:2]);
  assign record   = {wr_imem_i, word_idx, wr_data_i};
  assign counts   = wr_valid_i && (&wr_be_i) && (wr_addr_i[1:0] == 2'b00);
  assign crc_next = fold(crc_q, record);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        crc_q <= '1;
    else if (csum_we_i) crc_q <= ~csum_wdata_i;
    else if (counts)    crc_q <= crc_next;
  end

  assign csum_o = ~crc_q;

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |=> csum_o == 32'h0);

  assert_host_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csum_we_i |=> csum_o == $past(csum_wdata_i));

  assert_partial_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !csum_we_i && wr_be_i != 4'hF) |=> $stable(csum_o));

  assert_unaligned_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !csum_we_i && wr_addr_i[1:0] != 2'b00) |=> $stable(csum_o));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_valid_i && !csum_we_i) |=> $stable(csum_o));
endmodule

// File: tb/memload_crc_tb.sv
module memload_crc_tb;
  localparam int AW = 14;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_imem = 0, csum_we = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [3:0] wr_be = '0;
  logic [31:0] wr_data = '0, csum_wdata = '0, csum;
  int checks = 0, errors = 0;
  logic [31:0] model = 32'h0;

  always #10 clk = ~clk;

  memload_crc #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_imem_i(wr_imem),
    .wr_addr_i(wr_addr), .wr_be_i(wr_be), .wr_data_i(wr_data),
    .csum_we_i(csum_we), .csum_wdata_i(csum_wdata), .csum_o(csum));

  function automatic logic [31:0] sw_crc(input logic [31:0] vis, input logic flag,
                                         input logic [14:0] idx, input logic [31:0] d);
    logic [47:0] rec;
    logic [31:0] c;
    rec = {flag, idx, d};
    c = ~vis;
    for (int b = 0; b < 6; b++) begin
      c = c ^ {24'h0, rec[8*b +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (csum !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, csum, exp);
    end
  endtask

  task automatic mem_wr(input logic imem, input logic [AW-1:0] a, input logic [3:0] be,
                        input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1; wr_imem = imem; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
    if (be == 4'hF && a[1:0] == 2'b00) model = sw_crc(model, imem, 15'(a >> 2), d);
  endtask

  task automatic host_wr(input logic [31:0] v);
    @(negedge clk);
    csum_we = 1; csum_wdata = v;
    @(negedge clk);
    csum_we = 0;
    model = v;
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", 32'h0);

    // R6/R7 sweep of byte enables and address offsets
    for (int be = 0; be < 16; be++)
      for (int off = 0; off < 4; off++) begin
        mem_wr(be[0], AW'(16 + off), be[3:0], 32'hA5000000 | (be << 8) | off);
        if (be == 15 && off == 0) check("R2 R3 qualifying write", model);
        else if (be != 15)        check("R6 partial write ignored", model);
        else                      check("R7 unaligned write ignored", model);
      end

    // R4/R5 walking index and both memories
    for (int f = 0; f < 2; f++)
      for (int bit_i = 0; bit_i < AW - 2; bit_i++) begin
        mem_wr(f[0], AW'(1 << (bit_i + 2)), 4'hF, 32'h13579BDF ^ bit_i);
        check(f ? "R4 imem flag walking index R5" : "R4 dmem flag walking index R5", model);
      end
    mem_wr(1'b0, '1 << 2, 4'hF, 32'hFFFFFFFF);
    check("R5 top index zero-extended", model);

    // R8 host load then chaining
    host_wr(32'h0);
    check("R8 host clear", 32'h0);
    mem_wr(1'b1, AW'(0), 4'hF, 32'h00000013);
    check("R8 chained from zero", sw_crc(32'h0, 1'b1, 15'h0, 32'h00000013));
    host_wr(32'hDEADBEEF);
    check("R8 host load arbitrary", 32'hDEADBEEF);
    mem_wr(1'b0, AW'(8), 4'hF, 32'hCAFEF00D);
    check("R8 chained from loaded", sw_crc(32'hDEADBEEF, 1'b0, 15'h2, 32'hCAFEF00D));

    // R9 collision
    @(negedge clk);
    csum_we = 1; csum_wdata = 32'h12345678;
    wr_valid = 1; wr_imem = 1; wr_addr = AW'(4); wr_be = 4'hF; wr_data = 32'h55AA55AA;
    @(negedge clk);
    csum_we = 0; wr_valid = 0;
    model = 32'h12345678;
    check("R9 host wins collision", 32'h12345678);
    mem_wr(1'b0, AW'(12), 4'hF, 32'h0BADCAFE);
    check("R9 no trace of dropped write", sw_crc(32'h12345678, 1'b0, 15'h3, 32'h0BADCAFE));

    // R10 back-to-back
    host_wr(32'h0);
    @(negedge clk);
    wr_valid = 1; wr_be = 4'hF;
    for (int i = 0; i < 4; i++) begin
      wr_imem = i[0]; wr_addr = AW'(i * 4); wr_data = 32'h01010101 * (i + 1);
      model = sw_crc(model, i[0], 15'(i), 32'h01010101 * (i + 1));
      @(negedge clk);
      check("R10 back-to-back update", model);
    end
    wr_valid = 0;

    // R11 idle hold
    repeat (5) @(negedge clk);
    check("R11 idle hold", model);

    // R1 mid-run reset
    rst_n = 0;
    @(negedge clk);
    check("R1 reset mid-run", 32'h0);
    rst_n = 1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule